// File: doc/BRIEF.md
# Two-Register Stack-Caching Execute Datapath

This block is the execute stage of a small stack machine. The two topmost stack entries live in registers: the top of stack (TOS) and the next entry (NOS). All deeper entries live in a 256-word, 16-bit stack memory with one read port and one write port. A pointer register `sp` always addresses the entry directly beneath NOS.

Each cycle the block may receive one decoded operation. A decoded operation is an opcode, an 8-bit immediate and a 16-bit parameter word. The block applies one register transfer for it. A push spills NOS into memory at `sp+1`. A pop refills NOS from memory at `sp`. In both cases the memory access happens in the same cycle as the operation. The memory read is combinational and is captured into TOS or NOS at the end of the cycle. Writes take effect at the clock edge.

Variables share the same memory. They are reached through a variable-base register `vp` plus a sign-extended offset. The same offset scheme also works from the address held in TOS or in NOS.

The block has two named states:
- CLEAR is entered on reset. In CLEAR the block writes zero to every memory word, one word per cycle, and ignores all operations.
- RUN follows after the last word has been written. The transition CLEAR->RUN happens once, and RUN is never left except by reset.

Fetch, decode and subroutine control sit outside this block.

Top module: `stk_datapath`

## Requirements
- R1: Reset sets TOS, NOS, `sp` and `vp` to 0 and enters CLEAR with `ready` low. CLEAR zeroes all 256 memory words and raises `ready` exactly 256 clock edges after reset is released. Operations presented before `ready` is high change nothing.
- R2: A push (opcode 1: sign-extended immediate; opcode 2: parameter word) does four things: it puts the new value in TOS, moves the old TOS to NOS, writes the old NOS to memory at `sp+1`, and increments `sp`. The immediate is sign-extended from bit 7.
- R3: Every pop reloads NOS from memory at `sp` and decrements `sp`, wrapping from 0 to 255. The value reloaded is the one the word held before any write made in the same cycle. `sp` moves by at most one per cycle.
- R4: Opcode 3 pushes the memory word at `vp` plus the sign-extended immediate.
- R5: Opcode 4 replaces TOS with the memory word at TOS[7:0] plus the sign-extended immediate. NOS and `sp` are unchanged.
- R6: Opcode 5 writes TOS to NOS[7:0] plus the offset. Opcode 6 writes TOS to `vp` plus the offset. Both then pop: TOS takes NOS, and NOS is refilled as in R3.
- R7: Opcode 7 writes the sign-extended immediate to the address TOS[7:0] and keeps TOS. NOS is refilled and `sp` decremented.
- R8: Opcode 8 replaces TOS with a one-operand result selected by immediate[2:0]: 0 = bitwise NOT, 1 = negate, 2 = shift left by one, 3 = arithmetic shift right by one, any other value = TOS unchanged. NOS and `sp` are unchanged.
- R9: Opcode 9 writes to TOS a two-operand result selected by immediate[2:0], then refills NOS and decrements `sp`. The selections are: 0 = NOS+TOS, 1 = NOS-TOS, 2 = AND, 3 = OR, 4 = XOR, any other value = TOS.
- R10: Opcode 10 (duplicate) keeps TOS, copies TOS into NOS, writes the old NOS to memory at `sp+1`, and increments `sp`.
- R11: Opcode 11 loads `vp` with TOS[7:0] and then pops, with TOS taking NOS.
- R12: Opcode 0, opcodes 12 to 15, and any cycle with `op_valid` low leave TOS, NOS, `sp` and `vp` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | A decoded operation is present this cycle |
| op_code | input | 4 | Operation code (see requirements) |
| op_imm | input | 8 | Immediate: literal, offset or ALU function select |
| op_param | input | 16 | Parameter word for the push of opcode 2 |
| ready | output | 1 | High in RUN; low while memory is being cleared |
| tos | output | 16 | Top-of-stack register |
| nos | output | 16 | Next-on-stack register |
| sp | output | 8 | Pointer to the entry beneath NOS |
| vp | output | 8 | Variable-base register |

## Verification
The hardest case to reach from the ports is a store whose target address is the same word that the pop refill reads in that same cycle. The refill must return the old content, and the new value must land in memory for later reads. The bench reaches this case on purpose. It first pushes a literal computed from the current `sp`, which makes NOS+offset, or TOS, equal to the refill address. It then issues the store. A later pop brings the written word back into view. Pops continued past an empty stack drive `sp` through the wrap from 0 to 255. A long pseudo-random operation stream then mixes every opcode, including the undefined ones, against the bench's own model of the stack.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_LIT   = 4'd1,
        OP_LDPRM = 4'd2,
        OP_LDVAR = 4'd3,
        OP_LDIND = 4'd4,
        OP_STNXT = 4'd5,
        OP_STVAR = 4'd6,
        OP_STLIT = 4'd7,
        OP_ALU1  = 4'd8,
        OP_ALU2  = 4'd9,
        OP_DUP   = 4'd10,
        OP_SETVB = 4'd11
    } op_e;

    typedef enum logic [2:0] {
        ASRC_HOLD, ASRC_IMM, ASRC_PARAM, ASRC_MEM, ASRC_NOS, ASRC_ALU
    } asrc_e;

    typedef enum logic [1:0] {BSRC_HOLD, BSRC_TOS, BSRC_MEM} bsrc_e;
    typedef enum logic [1:0] {PTR_HOLD, PTR_INC, PTR_DEC} pact_e;
    typedef enum logic [1:0] {WA_SPILL, WA_EFF, WA_CLR} wasel_e;
    typedef enum logic [1:0] {WD_NOS, WD_TOS, WD_IMM, WD_ZERO} wdsel_e;
    typedef enum logic [1:0] {BASE_VAR, BASE_TOS, BASE_NOS} base_e;
    typedef enum logic {FSM_CLEAR, FSM_RUN} fsm_e;

    typedef struct packed {
        asrc_e  a_src;
        bsrc_e  b_src;
        pact_e  p_act;
        logic   wr_en;
        wasel_e wa_sel;
        wdsel_e wd_sel;
        base_e  base;
        logic   use_off;
        logic   rd_eff;
        logic   vp_load;
        logic   unary;
    } ctl_t;

    // one-operand function selects
    localparam logic [2:0] FN1_NOT = 3'd0;
    localparam logic [2:0] FN1_NEG = 3'd1;
    localparam logic [2:0] FN1_SHL = 3'd2;
    localparam logic [2:0] FN1_ASR = 3'd3;
    // two-operand function selects
    localparam logic [2:0] FN2_ADD = 3'd0;
    localparam logic [2:0] FN2_SUB = 3'd1;
    localparam logic [2:0] FN2_AND = 3'd2;
    localparam logic [2:0] FN2_OR  = 3'd3;
    localparam logic [2:0] FN2_XOR = 3'd4;

endpackage

// File: rtl/stk_alu.sv
module stk_alu
    import stk_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         unary,
    input  logic [2:0]   func,
    output logic [W-1:0] y
);

    always_comb begin
        y = a;
        if (unary) begin
            unique case (func)
                FN1_NOT: y = ~a;
                FN1_NEG: y = -a;
                FN1_SHL: y = {a[W-2:0], 1'b0};
                FN1_ASR: y = {a[W-1], a[W-1:1]};
                default: y = a;
            endcase
        end else begin
            unique case (func)
                FN2_ADD: y = b + a;
                FN2_SUB: y = b - a;
                FN2_AND: y = b & a;
                FN2_OR:  y = b | a;
                FN2_XOR: y = b ^ a;
                default: y = a;
            endcase
        end
    end

endmodule

// File: rtl/stk_ram.sv
module stk_ram #(
    parameter int W  = 16,
    parameter int AW = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // read sees the word as it was before this cycle's write
    assign rdata = mem[raddr];

endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
    import stk_pkg::*;
#(
    parameter int AW = 8,
    localparam logic [AW-1:0] LAST = {AW{1'b1}}
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [3:0]    op_code,
    output ctl_t          ctl,
    output logic          ready,
    output logic [AW-1:0] clr_addr
);

    fsm_e          state_q, state_d;
    logic [AW-1:0] clr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FSM_CLEAR;
            clr_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == FSM_CLEAR) clr_q <= clr_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FSM_CLEAR: if (clr_q == LAST) state_d = FSM_RUN;
            FSM_RUN:   state_d = FSM_RUN;
            default:   state_d = FSM_CLEAR;
        endcase
    end

    assign ready    = (state_q == FSM_RUN);
    assign clr_addr = clr_q;

    always_comb begin
        ctl = '0;
        unique case (state_q)
            FSM_CLEAR: begin
                ctl.wr_en  = 1'b1;
                ctl.wa_sel = WA_CLR;
                ctl.wd_sel = WD_ZERO;
            end
            FSM_RUN: if (op_valid) begin
                case (op_code)
                    OP_LIT, OP_LDPRM, OP_LDVAR: begin
                        ctl.a_src  = (op_code == OP_LIT)   ? ASRC_IMM :
                                     (op_code == OP_LDPRM) ? ASRC_PARAM : ASRC_MEM;
                        ctl.b_src  = BSRC_TOS;
                        ctl.p_act  = PTR_INC;
                        ctl.wr_en  = 1'b1;
                        ctl.wa_sel = WA_SPILL;
                        ctl.wd_sel = WD_NOS;
                        ctl.base    = BASE_VAR;
                        ctl.use_off = 1'b1;
                        ctl.rd_eff  = 1'b1;
                    end
                    OP_LDIND: begin
                        ctl.a_src   = ASRC_MEM;
                        ctl.base    = BASE_TOS;
                        ctl.use_off = 1'b1;
                        ctl.rd_eff  = 1'b1;
                    end
                    OP_STNXT, OP_STVAR: begin
                        ctl.a_src   = ASRC_NOS;
                        ctl.b_src   = BSRC_MEM;
                        ctl.p_act   = PTR_DEC;
                        ctl.wr_en   = 1'b1;
                        ctl.wa_sel  = WA_EFF;
                        ctl.wd_sel  = WD_TOS;
                        ctl.base    = (op_code == OP_STNXT) ? BASE_NOS : BASE_VAR;
                        ctl.use_off = 1'b1;
                    end
                    OP_STLIT: begin
                        ctl.b_src  = BSRC_MEM;
                        ctl.p_act  = PTR_DEC;
                        ctl.wr_en  = 1'b1;
                        ctl.wa_sel = WA_EFF;
                        ctl.wd_sel = WD_IMM;
                        ctl.base   = BASE_TOS;
                    end
                    OP_ALU1: begin
                        ctl.a_src = ASRC_ALU;
                        ctl.unary = 1'b1;
                    end
                    OP_ALU2: begin
                        ctl.a_src = ASRC_ALU;
                        ctl.b_src = BSRC_MEM;
                        ctl.p_act = PTR_DEC;
                    end
                    OP_DUP: begin
                        ctl.b_src  = BSRC_TOS;
                        ctl.p_act  = PTR_INC;
                        ctl.wr_en  = 1'b1;
                        ctl.wa_sel = WA_SPILL;
                        ctl.wd_sel = WD_NOS;
                    end
                    OP_SETVB: begin
                        ctl.vp_load = 1'b1;
                        ctl.a_src   = ASRC_NOS;
                        ctl.b_src   = BSRC_MEM;
                        ctl.p_act   = PTR_DEC;
                    end
                    default: ;
                endcase
            end
            default: ;
        endcase
    end

    // once running, only reset returns the block to clearing
    assert_run_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FSM_RUN) |=> (state_q == FSM_RUN));

    // R1: no operation ever moves the pointer while clearing
    assert_clear_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FSM_CLEAR) |-> (ctl.p_act == PTR_HOLD && !ctl.vp_load));

endmodule

// File: rtl/stk_datapath.sv
module stk_datapath
    import stk_pkg::*;
#(
    parameter int W     = 16,
    parameter int AW    = 8,
    parameter int IMM_W = 8,
    localparam logic [AW-1:0] ONE_P = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [3:0]       op_code,
    input  logic [IMM_W-1:0] op_imm,
    input  logic [W-1:0]     op_param,
    output logic             ready,
    output logic [W-1:0]     tos,
    output logic [W-1:0]     nos,
    output logic [AW-1:0]    sp,
    output logic [AW-1:0]    vp
);

    ctl_t          ctl;
    logic [AW-1:0] clr_addr;
    logic [W-1:0]  a_q, a_d, b_q, b_d, alu_y, rd_data, wr_data, imm_ext;
    logic [AW-1:0] p_q, p_d, vp_q, base_addr, eff_addr, wr_addr, rd_addr;

    assign imm_ext = {{(W-IMM_W){op_imm[IMM_W-1]}}, op_imm};

    stk_ctrl #(.AW(AW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_code  (op_code),
        .ctl      (ctl),
        .ready    (ready),
        .clr_addr (clr_addr)
    );

    stk_alu #(.W(W)) u_alu (
        .a     (a_q),
        .b     (b_q),
        .unary (ctl.unary),
        .func  (op_imm[2:0]),
        .y     (alu_y)
    );

    // address generation
    always_comb begin
        unique case (ctl.base)
            BASE_TOS: base_addr = a_q[AW-1:0];
            BASE_NOS: base_addr = b_q[AW-1:0];
            default:  base_addr = vp_q;
        endcase
        eff_addr = base_addr + (ctl.use_off ? imm_ext[AW-1:0] : '0);
        rd_addr  = ctl.rd_eff ? eff_addr : p_q;
        unique case (ctl.wa_sel)
            WA_EFF:  wr_addr = eff_addr;
            WA_CLR:  wr_addr = clr_addr;
            default: wr_addr = p_q + ONE_P;
        endcase
        unique case (ctl.wd_sel)
            WD_TOS:  wr_data = a_q;
            WD_IMM:  wr_data = imm_ext;
            WD_ZERO: wr_data = '0;
            default: wr_data = b_q;
        endcase
    end

    stk_ram #(.W(W), .AW(AW)) u_ram (
        .clk   (clk),
        .we    (ctl.wr_en),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    // register transfer selection
    always_comb begin
        unique case (ctl.a_src)
            ASRC_IMM:   a_d = imm_ext;
            ASRC_PARAM: a_d = op_param;
            ASRC_MEM:   a_d = rd_data;
            ASRC_NOS:   a_d = b_q;
            ASRC_ALU:   a_d = alu_y;
            default:    a_d = a_q;
        endcase
        unique case (ctl.b_src)
            BSRC_TOS: b_d = a_q;
            BSRC_MEM: b_d = rd_data;
            default:  b_d = b_q;
        endcase
        unique case (ctl.p_act)
            PTR_INC: p_d = p_q + ONE_P;
            PTR_DEC: p_d = p_q - ONE_P;
            default: p_d = p_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q  <= '0;
            b_q  <= '0;
            p_q  <= '0;
            vp_q <= '0;
        end else begin
            a_q <= a_d;
            b_q <= b_d;
            p_q <= p_d;
            if (ctl.vp_load) vp_q <= a_q[AW-1:0];
        end
    end

    assign tos = a_q;
    assign nos = b_q;
    assign sp  = p_q;
    assign vp  = vp_q;

    assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.wr_en && ctl.wa_sel == WA_CLR) |-> (wr_data == '0));

    assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (p_q == $past(p_q)) || (p_q == $past(p_q) + ONE_P)
                 || ($past(p_q) == p_q + ONE_P));

    assert_alu1_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && op_valid && op_code == OP_ALU1) |=>
        (b_q == $past(b_q) && p_q == $past(p_q)));

    assert_dup_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && op_valid && op_code == OP_DUP) |=>
        (a_q == $past(a_q) && b_q == $past(a_q) && p_q == $past(p_q) + ONE_P));

    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid) |=> ($stable(a_q) && $stable(b_q) && $stable(p_q) && $stable(vp_q)));

endmodule

// File: tb/test_stk_datapath.sv
module test_stk_datapath;
    import stk_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [7:0]  op_imm = '0;
    logic [15:0] op_param = '0;
    logic        ready;
    logic [15:0] tos, nos;
    logic [7:0]  sp, vp;

    always #(CLK_PERIOD/2) clk = ~clk;

    stk_datapath i_stk_datapath (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_imm(op_imm), .op_param(op_param), .ready(ready),
        .tos(tos), .nos(nos), .sp(sp), .vp(vp)
    );

    int checks = 0;
    int fails  = 0;

    // expectation scoreboard
    logic [15:0] q_tos[$], q_nos[$];
    logic [7:0]  q_sp[$], q_vp[$];
    string       q_tag[$];

    // bench stack model
    logic [15:0] m_a = '0, m_b = '0;
    logic [7:0]  m_p = '0, m_vp = '0;
    logic [15:0] m_mem [256];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    function automatic logic [15:0] sx(input logic [7:0] v);
        return {{8{v[7]}}, v};
    endfunction

    function automatic logic [15:0] f1(input logic [2:0] f, input logic [15:0] a);
        case (f)
            3'd0: return ~a;
            3'd1: return 16'd0 - a;
            3'd2: return a << 1;
            3'd3: return {a[15], a[15:1]};
            default: return a;
        endcase
    endfunction

    function automatic logic [15:0] f2(input logic [2:0] f, input logic [15:0] b, input logic [15:0] a);
        case (f)
            3'd0: return b + a;
            3'd1: return b - a;
            3'd2: return b & a;
            3'd3: return b | a;
            3'd4: return b ^ a;
            default: return a;
        endcase
    endfunction

    function automatic void m_push(input logic [15:0] v);
        m_mem[m_p + 8'd1] = m_b;
        m_b = m_a;
        m_a = v;
        m_p = m_p + 8'd1;
    endfunction

    // driver: presents one operation and queues the expected state
    task automatic issue(input logic [3:0] op, input logic [7:0] imm,
                         input logic [15:0] prm, input string tag);
        logic [15:0] rd, v;
        logic [7:0]  ad;
        @(negedge clk);
        op_valid = 1'b1; op_code = op; op_imm = imm; op_param = prm;
        rd = m_mem[m_p];
        case (op)
            4'd1:  m_push(sx(imm));
            4'd2:  m_push(prm);
            4'd3:  begin v = m_mem[m_vp + imm]; m_push(v); end
            4'd4:  m_a = m_mem[m_a[7:0] + imm];
            4'd5, 4'd6: begin
                ad = ((op == 4'd5) ? m_b[7:0] : m_vp) + imm;
                m_mem[ad] = m_a;
                m_a = m_b; m_b = rd; m_p = m_p - 8'd1;
            end
            4'd7:  begin m_mem[m_a[7:0]] = sx(imm); m_b = rd; m_p = m_p - 8'd1; end
            4'd8:  m_a = f1(imm[2:0], m_a);
            4'd9:  begin m_a = f2(imm[2:0], m_b, m_a); m_b = rd; m_p = m_p - 8'd1; end
            4'd10: begin m_mem[m_p + 8'd1] = m_b; m_b = m_a; m_p = m_p + 8'd1; end
            4'd11: begin m_vp = m_a[7:0]; m_a = m_b; m_b = rd; m_p = m_p - 8'd1; end
            default: ;
        endcase
        q_tos.push_back(m_a); q_nos.push_back(m_b);
        q_sp.push_back(m_p);  q_vp.push_back(m_vp);
        q_tag.push_back(tag);
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        op_valid = 1'b0;
        q_tos.push_back(m_a); q_nos.push_back(m_b);
        q_sp.push_back(m_p);  q_vp.push_back(m_vp);
        q_tag.push_back(tag);
    endtask

    // monitor: compares after each edge that consumed a queued item
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_tos.size() != 0) begin
                string t;
                t = q_tag.pop_front();
                chk({t, " tos"}, {16'd0, tos}, {16'd0, q_tos.pop_front()});
                chk({t, " nos"}, {16'd0, nos}, {16'd0, q_nos.pop_front()});
                chk({t, " sp"},  {24'd0, sp},  {24'd0, q_sp.pop_front()});
                chk({t, " vp"},  {24'd0, vp},  {24'd0, q_vp.pop_front()});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
    end

    initial begin
        int n;
        logic [15:0] lf;
        for (int k = 0; k < 256; k++) m_mem[k] = 16'hFFFF;
        repeat (3) @(negedge clk);
        chk("R1 reset tos", {16'd0, tos}, 32'd0);
        chk("R1 reset ready", {31'd0, ready}, 32'd0);
        // release reset with a push presented; it must be ignored
        rst_n = 1'b1; op_valid = 1'b1; op_code = OP_LIT; op_imm = 8'h55;
        n = 0;
        do begin @(posedge clk); #1; n++; end while (!ready && n < 1000);
        op_valid = 1'b0;
        chk("R1 clear length", n, 32'd256);
        chk("R1 ignored tos", {16'd0, tos}, 32'd0);
        chk("R1 ignored sp", {24'd0, sp}, 32'd0);
        for (int k = 0; k < 256; k++) m_mem[k] = 16'h0000;

        issue(OP_LIT, 8'h05, 16'h0, "R2 lit pos");
        issue(OP_LIT, 8'hFD, 16'h0, "R2 lit neg");
        issue(OP_LDPRM, 8'h00, 16'h1234, "R2 param");
        issue(OP_DUP, 8'h00, 16'h0, "R10 dup");
        issue(OP_ALU2, 8'd0, 16'h0, "R9 add");
        issue(OP_LIT, 8'h21, 16'h0, "R2 lit");
        issue(OP_ALU2, 8'd1, 16'h0, "R9 sub");
        for (int f = 0; f < 8; f++) issue(OP_ALU1, 8'(f), 16'h0, "R8 unary");
        issue(OP_LDPRM, 8'h00, 16'hF0F0, "R2 param");
        issue(OP_LDPRM, 8'h00, 16'h3C3C, "R2 param");
        issue(OP_ALU2, 8'd2, 16'h0, "R9 and");
        issue(OP_LDPRM, 8'h00, 16'h0FF0, "R2 param");
        issue(OP_ALU2, 8'd3, 16'h0, "R9 or");
        issue(OP_LDPRM, 8'h00, 16'h5555, "R2 param");
        issue(OP_ALU2, 8'd4, 16'h0, "R9 xor");
        issue(OP_LIT, 8'h07, 16'h0, "R2 lit");
        issue(OP_ALU2, 8'd6, 16'h0, "R9 default");
        // variable base and variable accesses
        issue(OP_LIT, 8'h40, 16'h0, "R2 lit");
        issue(OP_SETVB, 8'h00, 16'h0, "R11 set base");
        issue(OP_LDPRM, 8'h00, 16'hBEEF, "R2 param");
        issue(OP_STVAR, 8'hFE, 16'h0, "R6 store var neg off");
        issue(OP_LDVAR, 8'hFE, 16'h0, "R4 load var");
        issue(OP_LIT, 8'h3E, 16'h0, "R2 lit addr");
        issue(OP_LDIND, 8'h00, 16'h0, "R5 load ind");
        issue(OP_LIT, 8'h30, 16'h0, "R2 lit addr");
        issue(OP_LDIND, 8'h0E, 16'h0, "R5 load ind off");
        issue(OP_LIT, 8'h50, 16'h0, "R2 lit");
        issue(OP_LIT, 8'h11, 16'h0, "R2 lit");
        issue(OP_STNXT, 8'h02, 16'h0, "R6 store nos");
        issue(OP_LIT, 8'h52, 16'h0, "R2 lit");
        issue(OP_LDIND, 8'h00, 16'h0, "R6 readback");
        issue(OP_LIT, 8'h60, 16'h0, "R2 lit");
        issue(OP_STLIT, 8'h9C, 16'h0, "R7 store lit");
        issue(OP_LIT, 8'h60, 16'h0, "R2 lit");
        issue(OP_LDIND, 8'h00, 16'h0, "R7 readback");
        // store target equals refill address in the same cycle
        issue(OP_LIT, m_p + 8'd1, 16'h0, "R3 setup");
        issue(OP_LIT, 8'h77, 16'h0, "R3 setup");
        issue(OP_STNXT, 8'h01, 16'h0, "R3 store onto refill word");
        issue(OP_ALU2, 8'd7, 16'h0, "R3 refill after store");
        issue(OP_LIT, m_p + 8'd1, 16'h0, "R3 setup");
        issue(OP_STLIT, 8'h2A, 16'h0, "R3 stlit onto refill word");
        issue(OP_ALU2, 8'd7, 16'h0, "R3 refill after stlit");
        // undefined and idle cycles
        issue(4'd0, 8'h12, 16'h9999, "R12 nop");
        for (int c = 12; c < 16; c++) issue(4'(c), 8'h34, 16'h9999, "R12 undefined");
        idle("R12 idle");
        // drain below the bottom to wrap the pointer
        for (int k = 0; k < 40; k++) issue(OP_ALU2, 8'd7, 16'h0, "R3 pop wrap");
        // pseudo-random mix
        lf = 16'hACE1;
        for (int k = 0; k < 600; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            issue(lf[3:0], lf[11:4], {lf[7:0], lf[15:8]}, "R12 mixed stream");
        end
        idle("R12 idle");
        idle("R12 idle");
        repeat (3) @(negedge clk);
        report();
    end

endmodule